// File: doc/BRIEF.md
# Periodic Marker Frame Synchronizer

This block sits behind a bit-timing recovery stage and receives an already bit-aligned serial stream, one bit for every cycle on which `in_valid` is high. The transmitter places a short fixed marker (1 to 16 bits) once in every frame of `8*WORDS` bits. The block searches for the place where that marker lands and then follows it frame by frame. Once it has found the marker it reports the start of every frame and the word and bit position of each accepted bit.

The block tests one candidate alignment at a time. It compares the most recent `MARK_LEN` bits against the stored marker only on the bit where the candidate marker ends. A comparison counts as a hit when at least `THRESH` bit positions agree. When a search test fails, the candidate moves one bit later. Lock is declared only after `CONFIRM` hits in a row, one per frame, so a short marker, or data that happens to look like the marker, does not cause a false lock on one lucky match. While locked, single bad markers are tolerated. `MISS_MAX` misses in a row drop the lock and restart the search.

Top module: `frame_marker_sync`

## Requirements
- R1: While `rst_n` is low and after it is released, `locked`, `frame_start`, `word_index` and `bit_index` are all 0.
- R2: A bit is accepted only in a cycle with `in_valid` high. After a cycle with `in_valid` low, `frame_start` is 0 and `locked`, `word_index` and `bit_index` keep their values.
- R3: The frame position runs from 0 to `8*WORDS-1`. Position 0 is the first bit after the marker, and the marker fills the last `MARK_LEN` positions. The marker bit `MARK_VAL[MARK_LEN-1]` is sent first and `MARK_VAL[0]` last. On the bit at position `8*WORDS-1` the last `MARK_LEN` accepted bits are compared with the marker. The check is a hit when the number of agreeing bits is at least `THRESH`.
- R4: While searching, a miss moves the candidate one bit later. The position stays at `8*WORDS-1`, so the next accepted bit is checked again.
- R5: While searching, `CONFIRM` hits in a row raise `locked` in the cycle after the bit that completed the last hit. A miss restarts the count.
- R6: While locked, fewer than `MISS_MAX` misses in a row leave `locked` high, and any hit clears the miss count.
- R7: While locked, `MISS_MAX` misses in a row drop `locked` in the cycle after the last bad check. The block then returns to search and moves the candidate one bit later, as in R4.
- R8: `frame_start` is a one-cycle pulse in the cycle after an accepted bit at position 0, and only when `locked` is high. During the pulse `word_index` and `bit_index` are 0.
- R9: One cycle after each accepted bit, `word_index` holds that bit's position divided by 8 and `bit_index` holds the position modulo 8.
- R10: After reset the first accepted bit has position `8*WORDS-MARK_LEN`. The first marker check is therefore made on the `MARK_LEN`-th accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking an incoming bit |
| in_bit | input | 1 | Incoming serial bit |
| locked | output | 1 | Frame alignment confirmed |
| frame_start | output | 1 | Pulse for the first bit after the marker |
| word_index | output | $clog2(WORDS) | Word position of the last accepted bit |
| bit_index | output | 3 | Bit position inside the word of the last accepted bit |

## Verification
The bench builds the block with an 8-bit marker, `THRESH` of 7, 3 words per frame (24-bit frames), `CONFIRM` of 4 and `MISS_MAX` of 3. A threshold below the marker length means a single corrupted marker bit still counts as a hit, while three flipped bits count as a miss, so both sides of the threshold are exercised. The short frame lets hundreds of frames, several lock losses and relocks, and the searches that slide through random data fit into a short run. Idle cycles inserted between bits exercise the strobe handling at every frame position.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;

    typedef enum logic {
        MODE_SEARCH = 1'b0,
        MODE_TRACK  = 1'b1
    } sync_mode_e;

endpackage

// File: rtl/marker_correlator.sv
module marker_correlator #(
    parameter int          MARK_LEN = 8,
    parameter logic [15:0] MARK_VAL = 16'h00E2,
    parameter int          THRESH   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic hit
);
    localparam int AGR_W = $clog2(MARK_LEN + 1);

    logic [MARK_LEN-1:0] window;
    logic [AGR_W-1:0]    agree;

    generate
        if (MARK_LEN == 1) begin : g_single
            assign window = in_bit;
        end else begin : g_multi
            typedef struct packed {
                logic [MARK_LEN-2:0] hist;
            } corr_state_t;

            corr_state_t st_d, st_q;

            assign window = {st_q.hist, in_bit};

            always_comb begin
                st_d = st_q;
                if (in_valid) begin
                    st_d.hist = window[MARK_LEN-2:0];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

    always_comb begin
        agree = '0;
        for (int i = 0; i < MARK_LEN; i++) begin
            agree = agree + AGR_W'(window[i] == MARK_VAL[i]);
        end
    end

    assign hit = (agree >= AGR_W'(THRESH));

    // R3
    exact_marker_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && window == MARK_VAL[MARK_LEN-1:0]) |-> hit);

endmodule

// File: rtl/frame_pos_counter.sv
module frame_pos_counter #(
    parameter int WORDS    = 16,
    parameter int MARK_LEN = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              slip,
    output logic [$clog2(WORDS)+3-1:0]        pos,
    output logic                              at_check
);
    localparam int PERIOD    = 8 * WORDS;
    localparam int POS_W     = $clog2(WORDS) + 3;
    localparam int LAST_POS  = PERIOD - 1;
    localparam int START_POS = PERIOD - MARK_LEN;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign pos      = st_q.pos;
    assign at_check = (st_q.pos == POS_W'(LAST_POS));

    always_comb begin
        st_d = st_q;
        if (in_valid && !slip) begin
            if (at_check) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos <= POS_W'(START_POS);
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= POS_W'(LAST_POS));

    // R2
    idle_pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.pos));

    // R4
    slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slip) |=> (st_q.pos == POS_W'(LAST_POS)));

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
    import frame_sync_pkg::*;
#(
    parameter int CONFIRM  = 4,
    parameter int MISS_MAX = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic at_check,
    input  logic hit,
    output logic slip,
    output logic locked
);
    localparam int HIT_W  = $clog2(CONFIRM + 1);
    localparam int MISS_W = $clog2(MISS_MAX + 1);

    typedef struct packed {
        sync_mode_e         mode;
        logic [HIT_W-1:0]   hits;
        logic [MISS_W-1:0]  misses;
    } trk_state_t;

    trk_state_t st_d, st_q;

    assign locked = (st_q.mode == MODE_TRACK);

    always_comb begin
        st_d = st_q;
        slip = 1'b0;
        if (in_valid && at_check) begin
            case (st_q.mode)
                MODE_SEARCH: begin
                    if (hit) begin
                        if (st_q.hits == HIT_W'(CONFIRM - 1)) begin
                            st_d.mode   = MODE_TRACK;
                            st_d.hits   = '0;
                            st_d.misses = '0;
                        end else begin
                            st_d.hits = st_q.hits + HIT_W'(1);
                        end
                    end else begin
                        st_d.hits = '0;
                        slip      = 1'b1;
                    end
                end
                MODE_TRACK: begin
                    if (hit) begin
                        st_d.misses = '0;
                    end else if (st_q.misses == MISS_W'(MISS_MAX - 1)) begin
                        st_d.mode   = MODE_SEARCH;
                        st_d.hits   = '0;
                        st_d.misses = '0;
                        slip        = 1'b1;
                    end else begin
                        st_d.misses = st_q.misses + MISS_W'(1);
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_SEARCH;
            st_q.hits   <= '0;
            st_q.misses <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    hit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hits < HIT_W'(CONFIRM));

    // R7
    miss_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.misses < MISS_W'(MISS_MAX));

    // R5
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(st_q.hits) == HIT_W'(CONFIRM - 1) && $past(hit)));

    // R7
    lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(st_q.misses) == MISS_W'(MISS_MAX - 1) && !$past(hit)));

endmodule

// File: rtl/frame_marker_sync.sv
module frame_marker_sync #(
    parameter int          MARK_LEN = 8,
    parameter logic [15:0] MARK_VAL = 16'h00E2,
    parameter int          THRESH   = 8,
    parameter int          WORDS    = 16,
    parameter int          CONFIRM  = 4,
    parameter int          MISS_MAX = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_bit,
    output logic                      locked,
    output logic                      frame_start,
    output logic [$clog2(WORDS)-1:0]  word_index,
    output logic [2:0]                bit_index
);
    localparam int WORD_W = $clog2(WORDS);
    localparam int POS_W  = WORD_W + 3;

    typedef struct packed {
        logic              start;
        logic [WORD_W-1:0] word;
        logic [2:0]        bitn;
    } out_state_t;

    out_state_t       st_d, st_q;
    logic             hit;
    logic             slip;
    logic             at_check;
    logic [POS_W-1:0] pos;

    marker_correlator #(
        .MARK_LEN (MARK_LEN),
        .MARK_VAL (MARK_VAL),
        .THRESH   (THRESH)
    ) u_corr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .hit      (hit)
    );

    frame_pos_counter #(
        .WORDS    (WORDS),
        .MARK_LEN (MARK_LEN)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .slip     (slip),
        .pos      (pos),
        .at_check (at_check)
    );

    lock_tracker #(
        .CONFIRM  (CONFIRM),
        .MISS_MAX (MISS_MAX)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .at_check (at_check),
        .hit      (hit),
        .slip     (slip),
        .locked   (locked)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (in_valid) begin
            st_d.start = locked && (pos == '0);
            st_d.word  = pos[POS_W-1:3];
            st_d.bitn  = pos[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_start = st_q.start;
    assign word_index  = st_q.word;
    assign bit_index   = st_q.bitn;

    // R8
    start_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> locked);

    // R8
    start_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (word_index == '0 && bit_index == '0));

    // R8
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R2
    idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !frame_start);

endmodule

// File: tb/tb_frame_marker_sync.sv
module tb_frame_marker_sync;
    localparam int          ML   = 8;
    localparam logic [15:0] MV   = 16'h00E2;
    localparam int          TH   = 7;
    localparam int          NW   = 3;
    localparam int          KC   = 4;
    localparam int          MM   = 3;
    localparam int          P    = 8 * NW;
    localparam int          WW   = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_bit = 1'b0;
    logic          locked;
    logic          frame_start;
    logic [WW-1:0] word_index;
    logic [2:0]    bit_index;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit gaps_on = 1'b0;

    // bench reference state
    logic [15:0] m_hist = '0;
    int          m_pos = P - ML;
    bit          m_lock = 1'b0;
    int          m_hits = 0;
    int          m_miss = 0;

    frame_marker_sync #(
        .MARK_LEN (ML), .MARK_VAL (MV), .THRESH (TH),
        .WORDS (NW), .CONFIRM (KC), .MISS_MAX (MM)
    ) dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_bit (in_bit),
        .locked (locked), .frame_start (frame_start),
        .word_index (word_index), .bit_index (bit_index)
    );

    always #4 clk = ~clk;

    task automatic show_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
                show_summary();
                $finish;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit ref_hit(logic [15:0] h);
        int agree = 0;
        for (int i = 0; i < ML; i++) if (h[i] == MV[i]) agree++;
        return agree >= TH;
    endfunction

    task automatic idle_cycle();
        logic          l0 = locked;
        logic [WW-1:0] w0 = word_index;
        logic [2:0]    b0 = bit_index;
        in_valid = 1'b0;
        in_bit   = 1'($urandom);
        @(negedge clk);
        check("R2 idle frame_start", int'(frame_start), 0);
        check("R2 idle locked", int'(locked), int'(l0));
        check("R2 idle word_index", int'(word_index), int'(w0));
        check("R2 idle bit_index", int'(bit_index), int'(b0));
    endtask

    task automatic send_bit(bit b);
        bit e_fs;
        int e_w, e_b;
        bit slip;
        if (gaps_on && ($urandom % 8 == 0)) idle_cycle();
        e_fs = m_lock && (m_pos == 0);
        e_w  = m_pos / 8;
        e_b  = m_pos % 8;
        m_hist = {m_hist[14:0], b};
        slip = 1'b0;
        if (m_pos == P - 1) begin
            if (!m_lock) begin
                if (ref_hit(m_hist)) begin
                    m_hits++;
                    if (m_hits == KC) begin m_lock = 1'b1; m_hits = 0; m_miss = 0; end
                end else begin
                    m_hits = 0; slip = 1'b1;
                end
            end else begin
                if (ref_hit(m_hist)) m_miss = 0;
                else begin
                    m_miss++;
                    if (m_miss == MM) begin m_lock = 1'b0; m_miss = 0; m_hits = 0; slip = 1'b1; end
                end
            end
        end
        if (!slip) m_pos = (m_pos + 1) % P;
        in_valid = 1'b1;
        in_bit   = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5/R7 locked", int'(locked), int'(m_lock));
        check("R8 frame_start", int'(frame_start), int'(e_fs));
        check("R9 word_index", int'(word_index), e_w);
        check("R9 bit_index", int'(bit_index), e_b);
    endtask

    task automatic send_frame(int errs);
        for (int i = 0; i < P - ML; i++) send_bit(1'($urandom));
        for (int j = 0; j < ML; j++) send_bit(MV[ML-1-j] ^ (j < errs));
    endtask

    initial begin
        int fs_seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset locked", int'(locked), 0);
        check("R1 reset frame_start", int'(frame_start), 0);
        check("R1 reset word_index", int'(word_index), 0);
        check("R1 reset bit_index", int'(bit_index), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset locked", int'(locked), 0);

        // R10: first accepted bit sits at position P-ML
        send_bit(1'b0);
        check("R10 first word_index", int'(word_index), (P - ML) / 8);
        check("R10 first bit_index", int'(bit_index), (P - ML) % 8);

        // junk ahead of the first frame, then clean frames (R4 search slides)
        repeat (5 + $urandom % P) send_bit(1'($urandom));
        repeat (14) send_frame(0);
        check("R5 locked after clean frames", int'(locked), 1);

        fs_seen = 0;
        for (int i = 0; i < 2 * P; i++) begin
            send_bit(1'($urandom));
            if (frame_start) fs_seen++;
        end
        check("R8 one frame_start per frame", fs_seen, 2);

        // R3: one corrupted marker bit stays above threshold
        repeat (3) send_frame(1);
        check("R3 single-bit error tolerated", int'(locked), 1);

        // R6: MM-1 bad markers then a good one keep lock
        repeat (MM - 1) send_frame(3);
        check("R6 isolated misses tolerated", int'(locked), 1);
        send_frame(0);
        repeat (MM - 1) send_frame(3);
        check("R6 hit cleared miss count", int'(locked), 1);
        send_frame(0);

        // R7: MM bad markers in a row drop lock
        repeat (MM) send_frame(3);
        check("R7 lock lost", int'(locked), 0);
        // R4: after the slip the next bit is at the last position again
        send_bit(1'($urandom));
        check("R4 slip word_index", int'(word_index), NW - 1);
        check("R4 slip bit_index", int'(bit_index), 7);

        // relock with idle gaps between bits (R2)
        gaps_on = 1'b1;
        repeat (16) send_frame(0);
        check("R5 relocked with gaps", int'(locked), 1);

        // random error mix
        for (int f = 0; f < 300; f++) begin
            int r = $urandom % 10;
            send_frame(r < 6 ? 0 : (r < 8 ? 1 : 3));
        end
        gaps_on = 1'b0;

        show_summary();
        $finish;
    end

endmodule